// File: doc/BRIEF.md
# Serial Peripheral Frame Receiver with Device Addressing

This block is the serial front end of a small register-controlled peripheral. It accepts a four-wire serial bus in clock mode 0 or mode 3, plus a pause input and a pair of address strap pins. All pins are oversampled by a faster system clock, so the serial clock is never used as a clock. Each bus transfer is a frame bracketed by the active-low chip select.

The first byte of a frame is a header. It carries a fixed device-type code and a two-bit address, and the address must equal the strap pins. If the header matches, every later byte is handed to a command engine as a one-cycle strobe, along with the byte's position in the frame. From the first serial-clock fall after the second byte onward, the block shifts out a read byte that the engine supplies. If the header does not match, the frame is ignored and the output stays undriven.

The pause input freezes the serial state in the middle of a frame and releases the output. When chip select rises, the engine receives an end-of-frame pulse and a flag that tells it whether the frame ended on a byte boundary.

Top module: `spi_frame_front`

## Requirements
- R1: While reset is asserted and on the first cycle after it, so_oe_o, byte_valid_o, frame_end_o and addr_match_o are all 0.
- R2: A frame starts only when chip select is seen high and then low after reset. If chip select is held low through reset release, the clocked bytes produce no strobe, no match, no output enable and no frame-end pulse.
- R3: SI is captured on rising serial-clock edges, MSB first, with either idle level of the serial clock. Each completed byte after the header appears on byte_data_o together with a one-cycle byte_valid_o pulse.
- R4: The header is matched when bits [7:4] equal 4'b0101, bits [3:2] equal 2'b00 and bits [1:0] equal strap_i. addr_match_o shows the result from the header's completion until the next frame starts.
- R5: After a header that does not match, byte_valid_o never pulses and so_oe_o stays 0 for the rest of the frame.
- R6: byte_index_o reads 1 for the second byte of a frame, 2 for the third byte and 3 for every later byte. The header is never strobed.
- R7: rd_data_i is captured on the first serial-clock fall after the second byte completes. It is then presented on so_o MSB first, one bit per fall. The bytes after it read as zero.
- R8: so_oe_o is 1 only inside a matched frame that is not paused. It is 0 in the cycle frame_end_o pulses and stays 0 after chip select rises.
- R9: If hold_n_i goes low while the serial clock is low, the frame pauses. During the pause so_oe_o is 0 and toggles on SCK and SI change nothing.
- R10: If hold_n_i goes high while the serial clock is low, the frame resumes at the bit where it stopped.
- R11: A chip-select rise that ends a started frame produces a one-cycle frame_end_o pulse. frame_aligned_o is 1 only when the frame held a whole number of bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n_i | input | 1 | Chip select from the bus, active low |
| sck_i | input | 1 | Serial clock from the bus |
| si_i | input | 1 | Serial data into the block |
| hold_n_i | input | 1 | Pause request, active low |
| strap_i | input | ADDR_W | Board-level device address straps |
| rd_data_i | input | BYTE_W | Read byte from the command engine |
| so_o | output | 1 | Serial data out (0 when not enabled) |
| so_oe_o | output | 1 | Output enable for the serial data pad |
| byte_valid_o | output | 1 | One-cycle strobe for a received byte |
| byte_data_o | output | BYTE_W | The received byte |
| byte_index_o | output | 2 | Position of the strobed byte (1, 2, 3 = later) |
| addr_match_o | output | 1 | Header of the current or last frame matched |
| frame_end_o | output | 1 | One-cycle pulse when a frame is closed |
| frame_aligned_o | output | 1 | Closed frame ended on a byte boundary |

## Verification
The bench targets these corner cases:

- **Chip select held low through reset.** A design that treats the synchroniser's settling as a select edge would accept that frame.
- **Headers wrong in only one field** (address, type code or padding bit). A partial comparator would match them and drive SO.
- **A pause with serial-clock and data toggles in the middle of a byte.** A receiver that does not gate its edges would swallow extra bits and deliver a corrupted byte. One that keeps the output enabled would contend with another device on the bus.
- **A frame cut off mid-byte, and a five-byte frame.** These expose a wrong alignment flag, an index that wraps instead of saturating, a read byte loaded one edge late, and stale data repeated after the read byte.

// File: rtl/spi_fe_pkg.sv
// Package: shared types and defaults for the serial frame front end.
// Assumes a frame never needs more than four distinct byte positions.
package spi_fe_pkg;

    localparam int DEF_BYTE_W = 8;
    localparam int DEF_ADDR_W = 2;
    localparam int DEF_TYPE_W = 4;

    // Position of a byte within a frame; LATER saturates.
    typedef enum logic [1:0] {
        POS_FIRST  = 2'd0,
        POS_SECOND = 2'd1,
        POS_THIRD  = 2'd2,
        POS_LATER  = 2'd3
    } pos_e;

endpackage

// File: rtl/spi_fe_sync.sv
// Module: multi-stage synchroniser for a bundle of asynchronous pins.
// Assumes every bit is independent (no bus coherency needed) and
// that the reset value of 0 is harmless for every pin.
module spi_fe_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stg [STAGES];

    // Shift each pin through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/spi_fe_rx.sv
// Module: frame control and receive path. Detects select and clock
// edges, runs the pause state, assembles bytes MSB first, checks the
// header and strobes the later bytes.
// Assumes synchronised inputs and a serial clock at least four times
// slower than clk.
module spi_fe_rx
    import spi_fe_pkg::*;
#(
    parameter int         BYTE_W   = DEF_BYTE_W,
    parameter int         ADDR_W   = DEF_ADDR_W,
    parameter int         TYPE_W   = DEF_TYPE_W,
    parameter logic [3:0] DEV_TYPE = 4'b0101
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              sck_s,
    input  logic              si_s,
    input  logic              hold_s,
    input  logic [ADDR_W-1:0] strap_s,
    output logic              frame_start,
    output logic              active,
    output logic              paused,
    output logic              matched,
    output logic              sck_fall,
    output logic              bit_zero,
    output pos_e              pos,
    output logic              byte_valid,
    output logic [BYTE_W-1:0] byte_data,
    output pos_e              byte_index,
    output logic              frame_end,
    output logic              frame_aligned
);

    localparam int BIT_W = $clog2(BYTE_W);
    localparam int PAD_W = BYTE_W - TYPE_W - ADDR_W;
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

    logic              cs_d, sck_d;
    logic [BIT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] next_byte;
    logic [BYTE_W-1:0] header;
    logic              cs_rise, sck_rise, pause_enter, pause_exit;

    // Remember the previous synchronised levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_d  <= 1'b0;
            sck_d <= 1'b0;
        end else begin
            cs_d  <= cs_s;
            sck_d <= sck_s;
        end
    end

    assign frame_start = cs_d & ~cs_s;
    assign cs_rise     = ~cs_d & cs_s;
    assign sck_rise    = active & ~paused & sck_s & ~sck_d;
    assign sck_fall    = active & ~paused & ~sck_s & sck_d;
    assign pause_enter = active & ~paused & ~hold_s & ~sck_s;
    assign pause_exit  = paused & hold_s & ~sck_s;
    assign next_byte   = {shreg[BYTE_W-2:0], si_s};
    assign header      = {DEV_TYPE[TYPE_W-1:0], {PAD_W{1'b0}}, strap_s};
    assign bit_zero    = (bit_cnt == '0);

    // Frame state, pause, bit/byte counting, header match and strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active        <= 1'b0;
            paused        <= 1'b0;
            matched       <= 1'b0;
            bit_cnt       <= '0;
            pos           <= POS_FIRST;
            shreg         <= '0;
            byte_valid    <= 1'b0;
            byte_data     <= '0;
            byte_index    <= POS_FIRST;
            frame_end     <= 1'b0;
            frame_aligned <= 1'b0;
        end else begin
            byte_valid <= 1'b0;
            frame_end  <= 1'b0;
            if (cs_rise) begin
                frame_end     <= active;
                frame_aligned <= bit_zero;
                active        <= 1'b0;
                paused        <= 1'b0;
            end else if (frame_start) begin
                active  <= 1'b1;
                paused  <= 1'b0;
                matched <= 1'b0;
                bit_cnt <= '0;
                pos     <= POS_FIRST;
            end else if (active) begin
                if (pause_enter)     paused <= 1'b1;
                else if (pause_exit) paused <= 1'b0;
                if (sck_rise) begin
                    shreg   <= next_byte;
                    bit_cnt <= bit_cnt + 1'b1;
                    if (bit_cnt == LAST_BIT) begin
                        bit_cnt <= '0;
                        if (pos == POS_FIRST) matched <= (next_byte == header);
                        else                  byte_valid <= matched;
                        byte_data  <= next_byte;
                        byte_index <= pos;
                        if (pos != POS_LATER) pos <= pos_e'(pos + 2'd1);
                    end
                end
            end
        end
    end

    AST_VALID_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> matched); // R5
    AST_NO_HEADER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> byte_index != POS_FIRST); // R6
    AST_PAUSE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        paused |-> $stable(bit_cnt) && $stable(shreg)); // R9
    AST_END_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> !frame_end); // R11

endmodule

// File: rtl/spi_fe_tx.sv
// Module: transmit path. Loads the engine's read byte on the first
// serial-clock fall after the second byte and shifts it out MSB first.
// Assumes rd_data is stable from the second byte's strobe to that fall.
module spi_fe_tx
    import spi_fe_pkg::*;
#(
    parameter int BYTE_W = DEF_BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              sck_fall,
    input  logic              bit_zero,
    input  pos_e              pos,
    input  logic              active,
    input  logic              matched,
    input  logic              paused,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              so_out,
    output logic              so_oe
);

    logic [BYTE_W-1:0] tx_sh;

    // Clear at frame start, load the read byte or shift on each fall.
    always_ff @(posedge clk) begin
        if (!rst_n)                                       tx_sh <= '0;
        else if (frame_start)                             tx_sh <= '0;
        else if (sck_fall && bit_zero && pos == POS_THIRD) tx_sh <= rd_data;
        else if (sck_fall)                                tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
    end

    assign so_oe  = active & matched & ~paused;
    assign so_out = so_oe & tx_sh[BYTE_W-1];

endmodule

// File: rtl/spi_frame_front.sv
// Module: top of the serial frame front end. Synchronises the pins and
// wires the receive and transmit paths together.
// Assumes clk runs at least eight times faster than the serial clock.
module spi_frame_front
    import spi_fe_pkg::*;
#(
    parameter int         BYTE_W      = DEF_BYTE_W,
    parameter int         ADDR_W      = DEF_ADDR_W,
    parameter int         TYPE_W      = DEF_TYPE_W,
    parameter logic [3:0] DEV_TYPE    = 4'b0101,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_i,
    input  logic              sck_i,
    input  logic              si_i,
    input  logic              hold_n_i,
    input  logic [ADDR_W-1:0] strap_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic              so_o,
    output logic              so_oe_o,
    output logic              byte_valid_o,
    output logic [BYTE_W-1:0] byte_data_o,
    output logic [1:0]        byte_index_o,
    output logic              addr_match_o,
    output logic              frame_end_o,
    output logic              frame_aligned_o
);

    localparam int PIN_W = 4 + ADDR_W;

    logic [PIN_W-1:0]  pins_s;
    logic              cs_s, sck_s, si_s, hold_s;
    logic [ADDR_W-1:0] strap_s;
    logic              frame_start, active, paused, matched, sck_fall, bit_zero;
    pos_e              pos, byte_index;

    spi_fe_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n_i, sck_i, si_i, hold_n_i, strap_i}),
        .q     (pins_s)
    );

    assign {cs_s, sck_s, si_s, hold_s, strap_s} = pins_s;

    spi_fe_rx #(
        .BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .TYPE_W(TYPE_W), .DEV_TYPE(DEV_TYPE)
    ) u_rx (
        .clk           (clk),
        .rst_n         (rst_n),
        .cs_s          (cs_s),
        .sck_s         (sck_s),
        .si_s          (si_s),
        .hold_s        (hold_s),
        .strap_s       (strap_s),
        .frame_start   (frame_start),
        .active        (active),
        .paused        (paused),
        .matched       (matched),
        .sck_fall      (sck_fall),
        .bit_zero      (bit_zero),
        .pos           (pos),
        .byte_valid    (byte_valid_o),
        .byte_data     (byte_data_o),
        .byte_index    (byte_index),
        .frame_end     (frame_end_o),
        .frame_aligned (frame_aligned_o)
    );

    spi_fe_tx #(.BYTE_W(BYTE_W)) u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .sck_fall    (sck_fall),
        .bit_zero    (bit_zero),
        .pos         (pos),
        .active      (active),
        .matched     (matched),
        .paused      (paused),
        .rd_data     (rd_data_i),
        .so_out      (so_o),
        .so_oe       (so_oe_o)
    );

    assign byte_index_o = byte_index;
    assign addr_match_o = matched;

    AST_OE_OFF_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end_o |-> !so_oe_o); // R8

endmodule

// File: tb/spi_frame_front_bench.sv
module spi_frame_front_bench;

    localparam int HALF = 8;
    // {mode3, strap[1:0], header[7:0], command[7:0], read[7:0], expect_match}
    localparam logic [27:0] VEC [7] = '{
        {1'b0, 2'd0, 8'h50, 8'h9C, 8'hA5, 1'b1},
        {1'b0, 2'd3, 8'h53, 8'h21, 8'h3C, 1'b1},
        {1'b1, 2'd2, 8'h52, 8'hAF, 8'hC3, 1'b1},
        {1'b0, 2'd1, 8'h52, 8'h44, 8'h77, 1'b0},
        {1'b0, 2'd0, 8'h70, 8'h44, 8'h77, 1'b0},
        {1'b1, 2'd0, 8'h58, 8'h44, 8'h77, 1'b0},
        {1'b0, 2'd1, 8'h51, 8'h00, 8'hFF, 1'b1}
    };

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
    logic [1:0] strap = 2'd0;
    logic [7:0] rd = 8'h00;
    logic       so_o, so_oe, byte_valid, addr_match, frame_end, frame_aligned;
    logic [7:0] byte_data;
    logic [1:0] byte_index;

    spi_frame_front u_spi_frame_front (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sck_i(sck), .si_i(si),
        .hold_n_i(hold_n), .strap_i(strap), .rd_data_i(rd),
        .so_o(so_o), .so_oe_o(so_oe), .byte_valid_o(byte_valid),
        .byte_data_o(byte_data), .byte_index_o(byte_index),
        .addr_match_o(addr_match), .frame_end_o(frame_end),
        .frame_aligned_o(frame_aligned)
    );

    int  n_run = 0, n_fail = 0;
    bit  done = 1'b0, mode3 = 1'b0, oe_seen = 1'b0, mon_clr = 1'b0;
    logic [9:0] vlog [16];
    int  vcnt = 0, fecnt = 0;
    bit  fe_al = 1'b0;

    // Monitor: log strobes and frame ends just after each rising edge.
    always begin
        @(posedge clk);
        #2;
        if (mon_clr) begin
            vcnt  = 0;
            fecnt = 0;
        end else begin
            if (byte_valid && vcnt < 16) begin
                vlog[vcnt] = {byte_index, byte_data};
                vcnt++;
            end
            if (frame_end) begin
                fecnt++;
                fe_al = frame_aligned;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic half();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic clear_mon();
        mon_clr = 1'b1;
        @(negedge clk);
        @(negedge clk);
        mon_clr = 1'b0;
    endtask

    task automatic do_bit(input bit b, output bit so_b);
        if (mode3) begin
            sck = 1'b0; si = b; half();
            so_b = so_o; oe_seen |= so_oe;
            sck = 1'b1; half();
        end else begin
            si = b; half();
            so_b = so_o; oe_seen |= so_oe;
            sck = 1'b1; half();
            sck = 1'b0;
        end
    endtask

    task automatic do_byte(input logic [7:0] tx, output logic [7:0] rx);
        bit b;
        for (int i = 7; i >= 0; i--) begin
            do_bit(tx[i], b);
            rx[i] = b;
        end
    endtask

    task automatic frame_begin();
        sck = mode3; half();
        cs_n = 1'b0; half();
    endtask

    task automatic frame_close();
        half();
        cs_n = 1'b1;
        half(); half();
    endtask

    initial begin
        logic [27:0] e;
        logic [7:0]  hd, cm, rv, r, r3, r4;
        bit          em, b;

        // R1: reset state, with CS held low through reset for R2.
        cs_n = 1'b0;
        repeat (5) @(negedge clk);
        chk(!so_oe && !byte_valid && !frame_end && !addr_match, "R1 reset", so_oe, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!so_oe && !byte_valid && !frame_end && !addr_match, "R1 after release", addr_match, 0);
        clear_mon();
        oe_seen = 1'b0;
        do_byte(8'h50, r); do_byte(8'h11, r); do_byte(8'h00, r);
        chk(vcnt == 0, "R2 no strobe without select fall", vcnt, 0);
        chk(!addr_match && !oe_seen, "R2 no match/enable", addr_match, 0);
        cs_n = 1'b1; half(); half();
        chk(fecnt == 0, "R2 no frame end", fecnt, 0);

        // Vector table walk: R3 R4 R5 R6 R7 R8 R11.
        for (int v = 0; v < 7; v++) begin
            e = VEC[v];
            {mode3, strap, hd, cm, rv, em} = e;
            rd = rv;
            clear_mon();
            frame_begin();
            do_byte(hd, r);
            chk(addr_match == em, "R4 header match", addr_match, em);
            oe_seen = 1'b0;
            do_byte(cm, r);
            do_byte(8'h00, r3);
            frame_close();
            if (em) begin
                chk(vcnt == 2, "R3 strobe count", vcnt, 2);
                chk(vlog[0] == {2'd1, cm}, "R3 R6 second byte", vlog[0], {2'd1, cm});
                chk(vlog[1] == {2'd2, 8'h00}, "R6 third byte", vlog[1], {2'd2, 8'h00});
                chk(r3 == rv, "R7 read byte", r3, rv);
                chk(oe_seen, "R8 enable in matched frame", oe_seen, 1);
            end else begin
                chk(vcnt == 0, "R5 no strobe after mismatch", vcnt, 0);
                chk(!oe_seen, "R5 SO undriven", oe_seen, 0);
            end
            chk(fecnt == 1 && fe_al, "R11 aligned end", {fecnt, fe_al}, 3);
            chk(!so_oe, "R8 enable off after CS high", so_oe, 0);
        end

        // R9 R10: pause in the middle of the second byte (mode 0).
        mode3 = 1'b0; strap = 2'd0; rd = 8'h5A;
        clear_mon();
        frame_begin();
        do_byte(8'h50, r);
        do_bit(1'b1, b); do_bit(1'b0, b); do_bit(1'b1, b); do_bit(1'b1, b);
        chk(so_oe, "R8 enabled before pause", so_oe, 1);
        hold_n = 1'b0; half();
        chk(!so_oe, "R9 SO released in pause", so_oe, 0);
        for (int k = 0; k < 3; k++) begin
            si = ~si; sck = 1'b1; half();
            sck = 1'b0; half();
        end
        chk(vcnt == 0 && !so_oe, "R9 toggles ignored", vcnt, 0);
        hold_n = 1'b1; half();
        do_bit(1'b0, b); do_bit(1'b1, b); do_bit(1'b1, b); do_bit(1'b0, b);
        chk(vcnt == 1 && vlog[0] == {2'd1, 8'hB6}, "R10 resumed byte", vlog[0], {2'd1, 8'hB6});
        do_byte(8'hFF, r);
        chk(r == 8'h5A, "R10 R7 read after resume", r, 8'h5A);
        frame_close();

        // R11: frame closed mid-byte.
        clear_mon();
        frame_begin();
        do_byte(8'h50, r);
        for (int k = 0; k < 5; k++) do_bit(1'b1, b);
        frame_close();
        chk(fecnt == 1 && !fe_al, "R11 unaligned end", {fecnt, fe_al}, 2);
        chk(vcnt == 0, "R11 partial byte not strobed", vcnt, 0);

        // R6 R7: five-byte frame, index saturates and trailing bytes are zero.
        rd = 8'h81;
        clear_mon();
        frame_begin();
        do_byte(8'h50, r); do_byte(8'h12, r);
        do_byte(8'h00, r3); do_byte(8'h00, r4); do_byte(8'h00, r);
        frame_close();
        chk(vcnt == 4, "R6 strobe count", vcnt, 4);
        chk(vlog[2][9:8] == 2'd3 && vlog[3][9:8] == 2'd3, "R6 later index", vlog[3][9:8], 3);
        chk(r3 == 8'h81, "R7 read byte", r3, 8'h81);
        chk(r4 == 8'h00 && r == 8'h00, "R7 trailing zeros", {r4, r}, 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule